// File: doc/BRIEF.md
# Serial Port Frame Sync Unit

This block produces or qualifies the frame sync for one channel of a synchronous serial port. It marks the bit clock that carries the first data bit of each serial word with a `word_start` strobe, which the data shifter uses. It runs entirely on the bit clock.

The sync can be generated inside the block or taken from an external pin. An internal sync comes from a reload divider. It fires on every divider expiry in free-running mode. In buffer-gated mode it fires only when the divider expires and `buf_ok` reports transmit data ready or receive room.

In framed operation every word needs its own sync. In unframed operation one sync starts a block, and after that words follow back to back. The sync can be active high or active low. It can lead the first data bit by one bit clock (early) or coincide with it (late).

A small state machine controls the block:
- **ST_OFF**: the block is disabled. Controls are captured and the counters are cleared.
- **ST_HUNT**: the block is enabled and accepts syncs.
- **ST_STREAM**: an unframed block is running and word boundaries are generated automatically.

Transitions:
- **OFF→HUNT** when `en` is high.
- **HUNT→STREAM** on a word start in unframed mode.
- **HUNT/STREAM→OFF** when `en` is low.

Top module: `fsync_unit`

## Requirements
- R1: While reset is asserted, or while the block is disabled (`en` low at the previous clock edge), `fs_oe` and `word_start` are 0.
- R2: With `cfg_int_src`=1 the block drives the pin, so `fs_oe`=1 while enabled. With `cfg_int_src`=0 `fs_oe` stays 0 and `fs_in` is only sampled.
- R3: Cycle 0 is the first bit clock after enable. The internal divider expires on cycles `cfg_div`, 2·`cfg_div`+1, and so on, a period of `cfg_div`+1 bit clocks. A value of 0 expires every bit clock. Enabling again restarts the count from cycle 0.
- R4: In early timing (`cfg_late`=0) an accepted sync is active for exactly one bit clock, and `word_start` pulses on the next bit clock.
- R5: In late timing (`cfg_late`=1) an accepted sync and `word_start` occur in the same bit clock.
- R6: With `cfg_act_low`=1 the active sync level is 0 on both `fs_out` and `fs_in`. With `cfg_act_low`=0 the active level is 1. The inactive level is driven otherwise.
- R7: With `cfg_free_run`=0 an internal sync is produced only on a divider expiry in a cycle where `buf_ok`=1. With `cfg_free_run`=1 `buf_ok` has no effect.
- R8: In framed mode (`cfg_framed`=1), a sync that would start a word before the current word of `cfg_wlen` bits has ended is ignored. An early sync during the last bit is accepted, which gives back-to-back words.
- R9: In unframed mode (`cfg_framed`=0), the first word waits for a sync. After that, `word_start` pulses every `cfg_wlen` bit clocks (3 to 32), and further syncs are ignored and not driven.
- R10: Control and length inputs are captured only while disabled. Changing them while enabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable |
| cfg_int_src | input | 1 | 1: generate sync internally, 0: sample external pin |
| cfg_framed | input | 1 | 1: sync per word, 0: sync per block |
| cfg_free_run | input | 1 | 1: internal sync from divider only, 0: also needs `buf_ok` |
| cfg_act_low | input | 1 | 1: sync active low |
| cfg_late | input | 1 | 1: sync with first data bit, 0: one bit clock before |
| cfg_div | input | DIV_W | Divider reload value, period `cfg_div`+1 |
| cfg_wlen | input | LEN_W | Word length in bits, 3 to 32 |
| buf_ok | input | 1 | Transmit data ready or receive room available |
| fs_in | input | 1 | External frame sync pin |
| fs_out | output | 1 | Frame sync drive value |
| fs_oe | output | 1 | Frame sync output enable |
| word_start | output | 1 | First bit of a serial word |

## Verification
The bench looks for these corner cases and the failure each one would expose:
- **Divider of zero with a three-bit word.** A design that did not block a sync while a start is still pending would emit starts on adjacent clocks.
- **External sync in the middle of a word.** A design without the word gate would cut the current word short.
- **Early sync during the last bit.** A gate that is too strict would insert an idle bit between words.
- **Unframed streams.** These show whether later syncs restart the word count.
- **Polarity.** A swap would invert both pins.
- **Buffer gating.** It must hold syncs off while the buffer flag is low.
- **Control changes while running, and re-enabling.** These show whether the captured configuration leaks through and whether the divider keeps stale counts.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_STREAM
    } fs_state_e;

    typedef struct packed {
        logic int_src;
        logic framed;
        logic free_run;
        logic act_low;
        logic late;
    } fs_cfg_t;
endpackage

// File: rtl/fsync_div.sv
module fsync_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !clr && (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsync_word.sv
module fsync_word #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic [LEN_W-1:0] wlen,
    output logic [LEN_W-1:0] rem
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem <= '0;
        end else if (start) begin
            rem <= wlen - 1'b1;
        end else if (rem != '0) begin
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/fsync_unit.sv
module fsync_unit
    import fsync_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_int_src,
    input  logic             cfg_framed,
    input  logic             cfg_free_run,
    input  logic             cfg_act_low,
    input  logic             cfg_late,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [LEN_W-1:0] cfg_wlen,
    input  logic             buf_ok,
    input  logic             fs_in,
    output logic             fs_out,
    output logic             fs_oe,
    output logic             word_start
);
    localparam logic [LEN_W-1:0] LAST_BIT = LEN_W'(1);

    fs_state_e        state, nxt;
    fs_cfg_t          cfg_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] wlen_q;
    logic [LEN_W-1:0] rem;
    logic             tick, ws_pend, gate, sync_raw, accept, off;

    assign off = (state == ST_OFF);

    fsync_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (off),
        .limit (div_q),
        .tick  (tick)
    );

    fsync_word #(.LEN_W(LEN_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (off),
        .start (word_start),
        .wlen  (wlen_q),
        .rem   (rem)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (en) nxt = ST_HUNT;
            ST_HUNT:   if (!en) nxt = ST_OFF;
                       else if (word_start && !cfg_q.framed) nxt = ST_STREAM;
            ST_STREAM: if (!en) nxt = ST_OFF;
            default:   nxt = ST_OFF;
        endcase
    end

    // Configuration capture while disabled, pending early start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            div_q   <= '0;
            wlen_q  <= LEN_W'(3);
            ws_pend <= 1'b0;
        end else if (off) begin
            cfg_q   <= '{int_src: cfg_int_src, framed: cfg_framed,
                         free_run: cfg_free_run, act_low: cfg_act_low,
                         late: cfg_late};
            div_q   <= cfg_div;
            wlen_q  <= cfg_wlen;
            ws_pend <= 1'b0;
        end else begin
            ws_pend <= accept && !cfg_q.late;
        end
    end

    // Outputs
    always_comb begin
        sync_raw = cfg_q.int_src ? (tick && (cfg_q.free_run || buf_ok))
                                 : (fs_in ^ cfg_q.act_low);
        gate = 1'b0;
        unique case (state)
            ST_HUNT:   gate = cfg_q.late ? (rem == '0)
                                         : ((rem <= LAST_BIT) && !ws_pend);
            ST_OFF,
            ST_STREAM: gate = 1'b0;
            default:   gate = 1'b0;
        endcase
        accept     = sync_raw && gate;
        word_start = !off && (ws_pend || (accept && cfg_q.late)
                              || (state == ST_STREAM && rem == '0));
        fs_oe      = !off && cfg_q.int_src;
        fs_out     = cfg_q.act_low ^ (cfg_q.int_src && accept);
    end
endmodule

// File: rtl/fsync_unit_chk.sv
module fsync_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic fs_out,
    input logic fs_oe,
    input logic word_start,
    input logic int_src,
    input logic act_low,
    input logic late
);
    logic fs_active;
    assign fs_active = fs_oe && (fs_out != act_low);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (!fs_oe && !word_start));

    // R2
    ext_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_src |-> !fs_oe);

    // R4
    early_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_active && !late && en) |=> word_start);

    // R4
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_active |=> !fs_active);

    // R5
    late_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_active && late) |-> word_start);

    // R8
    ws_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !word_start);
endmodule

bind fsync_unit fsync_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .fs_out     (fs_out),
    .fs_oe      (fs_oe),
    .word_start (word_start),
    .int_src    (cfg_q.int_src),
    .act_low    (cfg_q.act_low),
    .late       (cfg_q.late)
);

// File: tb/sim_fsync_unit.sv
`timescale 1ns/1ps
module sim_fsync_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_int_src = 1'b0, cfg_framed = 1'b1, cfg_free_run = 1'b1;
    logic        cfg_act_low = 1'b0, cfg_late = 1'b0;
    logic [11:0] cfg_div = '0;
    logic [5:0]  cfg_wlen = 6'd8;
    logic        buf_ok = 1'b0;
    logic        fs_in = 1'b0;
    logic        fs_out, fs_oe, word_start;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    fsync_unit u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_int_src(cfg_int_src), .cfg_framed(cfg_framed),
        .cfg_free_run(cfg_free_run), .cfg_act_low(cfg_act_low),
        .cfg_late(cfg_late), .cfg_div(cfg_div), .cfg_wlen(cfg_wlen),
        .buf_ok(buf_ok), .fs_in(fs_in),
        .fs_out(fs_out), .fs_oe(fs_oe), .word_start(word_start)
    );

    task automatic cmp(input string tag, input int c, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, c, act, exp);
        end
    endtask

    task automatic setup(input logic isrc, input logic framed, input logic free,
                         input logic alow, input logic late, input int div, input int wl);
        @(negedge clk);
        en = 1'b0;
        cfg_int_src = isrc; cfg_framed = framed; cfg_free_run = free;
        cfg_act_low = alow; cfg_late = late;
        cfg_div = 12'(div); cfg_wlen = 6'(wl);
        fs_in = alow;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        repeat (3) @(negedge clk);
        cmp("R1 reset fs_oe", 0, fs_oe, 0);
        cmp("R1 reset word_start", 0, word_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 disabled fs_oe", 0, fs_oe, 0);
    endtask

    // R3 R4 R6 R7 R10: internal framed early, period div+1, buf_ok ignored
    task automatic t_int_early(input logic alow, input int n, input logic poke, input string tag);
        setup(1, 1, 1, alow, 0, 9, 8);
        buf_ok = 1'b0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (poke && c == 3) begin
                cfg_late = 1'b1; cfg_div = 12'd2; cfg_act_low = ~alow; cfg_wlen = 6'd3;
            end
            #1;
            cmp({tag, " R2 fs_oe"}, c, fs_oe, 1);
            cmp({tag, " R3 R4 R6 fs_out"}, c, fs_out, int'(alow ^ (c % 10 == 9)));
            cmp({tag, " R4 word_start"}, c, word_start, int'(c % 10 == 0 && c > 0));
        end
    endtask

    // R5: internal late timing
    task automatic t_int_late();
        setup(1, 1, 1, 0, 1, 9, 8);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk); #1;
            cmp("R5 fs_out", c, fs_out, int'(c % 10 == 9));
            cmp("R5 word_start", c, word_start, int'(c % 10 == 9));
        end
    endtask

    // R3 R8: divider zero with three-bit word, both timings
    task automatic t_div0(input logic late);
        setup(1, 1, 1, 0, late, 0, 3);
        for (int c = 0; c < 12; c++) begin
            @(negedge clk); #1;
            cmp("R3 R8 div0 fs_out", c, fs_out, int'(c % 3 == 0));
            cmp("R3 R8 div0 word_start", c, word_start,
                int'(late ? (c % 3 == 0) : (c % 3 == 1)));
        end
    endtask

    // R7: buffer gating
    task automatic t_gated();
        setup(1, 1, 0, 0, 0, 4, 4);
        buf_ok = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (c == 15) buf_ok = 1'b1;
            #1;
            cmp("R7 gated fs_out", c, fs_out, int'(c >= 15 && c % 5 == 4));
            cmp("R7 gated word_start", c, word_start, int'(c >= 20 && c % 5 == 0));
        end
    endtask

    // R2 R6 R8: external framed, mid-word sync ignored
    task automatic t_ext(input logic late);
        int p0, p1, p2, w0, w1;
        setup(0, 1, 1, 1, late, 0, 5);
        p0 = 2; p1 = late ? 4 : 6; p2 = 7;
        w0 = late ? 2 : 3; w1 = late ? 7 : 8;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            fs_in = (c == p0 || c == p1 || c == p2) ? 1'b0 : 1'b1;
            #1;
            cmp("R2 ext fs_oe", c, fs_oe, 0);
            cmp("R6 R8 ext word_start", c, word_start, int'(c == w0 || c == w1));
        end
        fs_in = 1'b1;
    endtask

    // R9: unframed internal early stream
    task automatic t_unframed_int();
        setup(1, 0, 1, 0, 0, 5, 4);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk); #1;
            cmp("R9 unframed fs_out", c, fs_out, int'(c == 5));
            cmp("R9 unframed word_start", c, word_start, int'(c >= 6 && (c - 6) % 4 == 0));
        end
    endtask

    // R9: unframed external late, later syncs ignored
    task automatic t_unframed_ext();
        setup(0, 0, 1, 0, 1, 0, 6);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            fs_in = (c == 3 || c == 5 || c == 12) ? 1'b1 : 1'b0;
            #1;
            cmp("R9 unframed ext word_start", c, word_start, int'(c >= 3 && (c - 3) % 6 == 0));
        end
        fs_in = 1'b0;
    endtask

    // R1: disabled after running
    task automatic t_disable();
        @(negedge clk); en = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        cmp("R1 off fs_oe", 0, fs_oe, 0);
        cmp("R1 off word_start", 0, word_start, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_int_early(0, 14, 0, "R3 partial");
        t_int_early(0, 40, 0, "R3 reenable");
        t_int_early(1, 40, 0, "R6 low");
        t_int_early(0, 40, 1, "R10 poke");
        t_int_late();
        t_div0(0);
        t_div0(1);
        t_gated();
        t_ext(1);
        t_ext(0);
        t_unframed_int();
        t_unframed_ext();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule